// File: doc/BRIEF.md
# Demodulated Product Low-Pass Filter and Scaler

This block receives the stream of products from one demodulation path and runs it through a cascade of first-order recursive low-pass sections. The cutoff is set by a shift amount, and the number of active sections can be chosen at run time. The last active section drives a 27-bit measurement output that keeps the full resolution for readout.

The same filtered value also feeds a scaler. The scaler applies a power-of-two gain, drops the low bits so that the result lines up with a 14-bit range, and saturates it. The 14-bit output can drive a DAC or a control loop directly. Several paths that run at the same frequency can share one set of cutoff, order and gain settings by connecting the same configuration inputs to several instances.

Top module: `demod_lpf_scaler`

## Requirements
- R1: After a synchronous reset, `filt_o` and `scaled_o` are both 0.
- R2: On a clock edge with `prod_vld_i` high, each active section updates as y <= y + floor((u - y) / 2^k). Here k is `cut_shift_i` and u is the section's input: `prod_i` for section 0, and the previous state of section i-1 for section i.
- R3: On a clock edge with `prod_vld_i` low and `order_sel_i` unchanged, `filt_o` keeps its value whatever `prod_i` carries.
- R4: `order_sel_i` = n cascades sections 0..n (n+1 sections), and `filt_o` is the state of section n. With k = 0, each section adds exactly one valid-sample delay.
- R5: Sections above the selected order are forced to 0 at every clock edge. A section that is enabled again therefore starts from 0.
- R6: `scaled_o` = floor(`filt_o` * 2^g / 2^13), where g is the effective gain. It follows `filt_o` and `gain_i` without a register.
- R7: A `gain_i` value above 13 acts as 13.
- R8: A scaled value above +8191 gives +8191, and one below -8192 gives -8192. Values never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prod_i | input | 27 | Signed demodulated product sample |
| prod_vld_i | input | 1 | Sample strobe; the filter advances only when high |
| cut_shift_i | input | 5 | Cutoff shift k of every section |
| order_sel_i | input | 2 | Active section count minus one |
| gain_i | input | 4 | Power-of-two gain exponent, 0 to 13 |
| filt_o | output | 27 | Signed filtered measurement value |
| scaled_o | output | 14 | Signed gained and saturated value |

## Verification
The bench builds the block with its default parameters: a 27-bit datapath, a 14-bit output, four sections and a 4-bit gain field. This makes the largest gain of 13, gain codes 14 and 15 beyond it, and both extremes of the 27-bit range reachable. A zero cutoff shift loads a chosen value straight into the first section. That lets the scaler table reach the exact saturation edges at ±8192. Settings of all four sections expose the per-section sample delay and the zeroing of re-enabled sections.

// File: rtl/demod_lpf_scaler.sv
module demod_lpf_scaler #(
  parameter int DATA_W   = 27,
  parameter int OUT_W    = 14,
  parameter int SHIFT_W  = 5,
  parameter int SECTIONS = 4,
  parameter int GAIN_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic signed [DATA_W-1:0]  prod_i,
  input  logic                      prod_vld_i,
  input  logic [SHIFT_W-1:0]        cut_shift_i,
  input  logic [$clog2(SECTIONS)-1:0] order_sel_i,
  input  logic [GAIN_W-1:0]         gain_i,
  output logic signed [DATA_W-1:0]  filt_o,
  output logic signed [OUT_W-1:0]   scaled_o
);
  localparam int ORD_W    = $clog2(SECTIONS);
  localparam int MAX_GAIN = DATA_W - OUT_W;
  localparam int WIDE_W   = DATA_W + MAX_GAIN;
  localparam logic signed [WIDE_W-1:0] HI = WIDE_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [WIDE_W-1:0] LO = ~HI;

  logic signed [DATA_W-1:0] st [SECTIONS];

  genvar i;
  generate
    for (i = 0; i < SECTIONS; i++) begin : g_sec
      localparam logic [ORD_W-1:0] IDX = ORD_W'(i);
      logic signed [DATA_W-1:0] src;
      logic signed [DATA_W:0]   diff;
      logic signed [DATA_W:0]   step;

      if (i == 0) begin : g_head
        assign src = prod_i;
      end else begin : g_tail
        assign src = st[i-1];
      end

      assign diff = {src[DATA_W-1], src} - {st[i][DATA_W-1], st[i]};
      assign step = diff >>> cut_shift_i;

      always_ff @(posedge clk) begin
        if (rst || IDX > order_sel_i)
          st[i] <= '0;
        else if (prod_vld_i)
          st[i] <= st[i] + step[DATA_W-1:0];
      end
    end
  endgenerate

  assign filt_o = st[order_sel_i];

  logic [GAIN_W-1:0]         gain_eff;
  logic signed [WIDE_W-1:0]  wide, lifted, aligned;

  assign gain_eff = (gain_i > GAIN_W'(MAX_GAIN)) ? GAIN_W'(MAX_GAIN) : gain_i;
  assign wide     = {{MAX_GAIN{filt_o[DATA_W-1]}}, filt_o};
  assign lifted   = wide <<< gain_eff;
  assign aligned  = lifted >>> MAX_GAIN;

  assign scaled_o = (aligned > HI) ? HI[OUT_W-1:0] :
                    (aligned < LO) ? LO[OUT_W-1:0] :
                    aligned[OUT_W-1:0];
endmodule

module demod_lpf_scaler_chk #(
  parameter int DATA_W   = 27,
  parameter int OUT_W    = 14,
  parameter int SHIFT_W  = 5,
  parameter int SECTIONS = 4,
  parameter int GAIN_W   = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic signed [DATA_W-1:0]    prod_i,
  input logic                        prod_vld_i,
  input logic [SHIFT_W-1:0]          cut_shift_i,
  input logic [$clog2(SECTIONS)-1:0] order_sel_i,
  input logic [GAIN_W-1:0]           gain_i,
  input logic signed [DATA_W-1:0]    filt_o,
  input logic signed [OUT_W-1:0]     scaled_o
);
  localparam int MAX_GAIN = DATA_W - OUT_W;
  localparam logic signed [DATA_W-1:0] TOP = DATA_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (filt_o == '0 && scaled_o == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !prod_vld_i |=> (!$stable(order_sel_i) || $stable(filt_o)));

  // R4
  passthrough_chk: assert property (@(posedge clk) disable iff (rst)
    (prod_vld_i && cut_shift_i == '0 && order_sel_i == '0)
      |=> (order_sel_i != '0 || filt_o == $past(prod_i)));

  // R8
  sat_top_chk: assert property (@(posedge clk) disable iff (rst)
    (gain_i >= GAIN_W'(MAX_GAIN) && filt_o > TOP) |-> scaled_o == TOP[OUT_W-1:0]);

  // R6
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    scaled_o[OUT_W-1] == filt_o[DATA_W-1]);
endmodule

bind demod_lpf_scaler demod_lpf_scaler_chk #(
  .DATA_W(DATA_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W),
  .SECTIONS(SECTIONS), .GAIN_W(GAIN_W)
) u_chk (.*);

// File: tb/demod_lpf_scaler_test.sv
module demod_lpf_scaler_test;
  localparam int CLK_P = 10;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [26:0] prod_i = '0;
  logic               prod_vld_i = 1'b0;
  logic [4:0]         cut_shift_i = '0;
  logic [1:0]         order_sel_i = '0;
  logic [3:0]         gain_i = '0;
  logic signed [26:0] filt_o;
  logic signed [13:0] scaled_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  demod_lpf_scaler uut (.*);

  // value, gain, expected scaled
  localparam longint VEC [13][3] = '{
    '{1000000, 0, 122},
    '{1000000, 3, 976},
    '{1000000, 7, 8191},
    '{-1000000, 7, -8192},
    '{-1000000, 0, -123},
    '{-1, 0, -1},
    '{8191, 13, 8191},
    '{8192, 13, 8191},
    '{-8192, 13, -8192},
    '{-8193, 13, -8192},
    '{67108863, 0, 8191},
    '{-67108864, 0, -8192},
    '{100, 15, 100}
  };

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; prod_vld_i = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic sample(input longint x);
    @(negedge clk); prod_i = 27'(x); prod_vld_i = 1'b1;
    @(negedge clk); prod_vld_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 filt after reset", filt_o, 0);
    check("R1 scaled after reset", scaled_o, 0);

    for (int n = 0; n < 13; n++) begin
      order_sel_i = 2'd0; cut_shift_i = 5'd0;
      sample(VEC[n][0]);
      gain_i = 4'(VEC[n][1]);
      #1;
      check($sformatf("R6 R7 R8 vector %0d", n), scaled_o, VEC[n][2]);
    end

    do_reset();
    gain_i = 4'd0; cut_shift_i = 5'd2; order_sel_i = 2'd0;
    sample(4096); check("R2 step 1", filt_o, 1024);
    sample(4096); check("R2 step 2", filt_o, 1792);
    sample(4096); check("R2 step 3", filt_o, 2368);

    @(negedge clk); prod_i = -27'sd30000;
    repeat (2) @(negedge clk);
    check("R3 idle hold", filt_o, 2368);

    do_reset();
    cut_shift_i = 5'd1;
    sample(-5); check("R2 negative floor 1", filt_o, -3);
    sample(-5); check("R2 negative floor 2", filt_o, -4);

    do_reset();
    cut_shift_i = 5'd0; order_sel_i = 2'd1;
    sample(500); check("R4 two sections first", filt_o, 0);
    sample(600); check("R4 two sections second", filt_o, 500);

    do_reset();
    order_sel_i = 2'd3;
    sample(700); sample(700); sample(700);
    check("R4 four sections third", filt_o, 0);
    sample(700);
    check("R4 four sections fourth", filt_o, 700);

    order_sel_i = 2'd0;
    @(negedge clk);
    check("R4 order one view", filt_o, 700);
    order_sel_i = 2'd3;
    #1;
    check("R5 re-enabled section cleared", filt_o, 0);
    sample(700);
    check("R5 re-enabled chain restarts", filt_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule